// File: doc/BRIEF.md
# Chainable 24-bit Serial Register Port

This block is a serial slave port that gives a host read and write access to a small bank of 16-bit registers. Each transfer is framed by an active-low select line. While the select is low, the host clocks data in on a serial input. Every 24-bit word has the same layout. The top bit chooses read (1) or write (0). The next seven bits name a register. The low sixteen bits carry data. Words are sent most significant bit first. The block acts only when the select rises, and only if the number of serial clock falling edges in the frame was a whole, non-zero multiple of 24. In that case it decodes the last 24 bits it received and ignores the rest.

A read takes two frames. The frame that carries the read command arms the request. During the next frame, whatever it carries, the register contents leave on the serial output in word positions 9 to 24. The serial output doubles as the chain output. From position 25 onward it repeats the serial input 24 positions late, so the output of one device can feed the input of the next device. To address a chain of devices, the host sends the word for the farthest device first. Whenever the output is not carrying read or forwarded data, it is released to high impedance. The `sdo_oe` pin tells the pad to drive, and an external pull-up sets the line level when the pad is released.

All pins are sampled with the system clock `clk`, which must run well above the serial clock. The serial clock idles low. The input is captured on its falling edges, and the output moves after its rising edges.

Top module: `spi_dc_slave`

## Requirements
- R1: When reset is held low at a rising clk edge, all registers, the pending-read flag and `sdo_oe` are cleared.
- R2: A frame of exactly 24 falling edges with bit 23 = 0 writes bits 15..0 into the register whose address is in bits 22..16. Bits are sent most significant first.
- R3: A frame of 24·k falling edges, for any k ≥ 1, is decoded from its last 24 bits only. Earlier bits are not decoded.
- R4: A frame whose falling-edge count is not a multiple of 24 writes no register. It also leaves no read pending, even if a read was pending before that frame.
- R5: A valid frame with bit 23 = 1 arms a read of the addressed register. In the next frame, positions 9..24 carry register bits 15..0, most significant first, with `sdo_oe` high. Positions 1..8 of that frame keep `sdo_oe` low.
- R6: `sdo_oe` is low while the select is high. It is also low in positions 1..24 of any frame that follows a frame with no armed read.
- R7: From position 25 of a frame onward, `sdo_oe` is high and `sdo` carries the serial input bit received 24 positions earlier.
- R8: Registers exist only at addresses 0..7. A read of any other address returns zero, and a write to any other address changes no register.
- R9: The serial input is taken on falling edges of the serial clock. Serial clock edges while the select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, command or chained data |
| sdo | output | 1 | Serial data out, read data or forwarded input |
| sdo_oe | output | 1 | Drive enable for the sdo pad; low means high impedance |

## Verification
Three instances are wired in a chain, with pull-ups modelled on every released output, and the host watches only the last device's output. A bad bit in a shift register therefore reaches the host 24, 48 or 72 positions later, inside the frame that follows. A wrong edge count shows up one frame later, as an unexpected write or a missing write in a read-back. A stuck pending-read flag shows up in the next frame as driven data in positions that should read as pull-up ones. Frames of 23, 25, 72 and 96 edges are used so that errors in the modulo count and in the last-24-bits rule appear at the ports.

// File: rtl/spi_dc_pkg.sv
// Shared constants and pin bundle for the chainable serial register port.
// Assumes a command byte of one direction bit followed by the address.
package spi_dc_pkg;
    localparam int CMD_W = 8;

    // Raw serial pins grouped for a single synchronizer.
    typedef struct packed {
        logic sdi;
        logic sclk;
        logic sync_n;
    } spi_pins_t;

    localparam int PINS_W = $bits(spi_pins_t);
endpackage

// File: rtl/spi_dc_sync.sv
// Two-stage synchronizer for a bundle of asynchronous pins.
// Assumes every pin is slow compared with clk, so skew between bits is harmless.
module spi_dc_sync #(
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    // Two flops in series per bit bring the pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/spi_dc_frame.sv
// Frame engine: detects edges, shifts input, counts edges modulo the word
// length, checks the frame at its end, and drives the serial output and its enable.
// Assumes synchronized pins and a serial clock that idles low.
module spi_dc_frame #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int CMD_W   = 1 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL_POS = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] HDR_POS  = CNT_W'(CMD_W);

    logic               sclk_q, sync_q;
    logic               sclk_rise, sclk_fall, sync_fall, sync_rise, in_frame;
    logic [FRAME_W-1:0] sr, preload;
    logic [CNT_W-1:0]   mod_cnt, out_pos;
    logic               got_edge, armed, frame_ok, is_rd, sdo_q;
    logic [ADDR_W-1:0]  arm_addr;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign sync_fall = ~sync_n_s & sync_q;
    assign sync_rise = sync_n_s & ~sync_q;
    assign in_frame  = ~sync_n_s;
    assign frame_ok  = got_edge && (mod_cnt == '0);
    assign is_rd     = sr[FRAME_W-1];
    assign preload   = armed ? {{CMD_W{1'b0}}, rd_data} : '0;

    // Keep the previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sync_q <= sync_n_s;
        end
    end

    // Load read data at frame start, then shift input bits on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr <= '0;
        else if (sync_fall)              sr <= preload;
        else if (in_frame && sclk_fall)  sr <= {sr[FRAME_W-2:0], sdi_s};
    end

    // Count falling edges modulo the word length, and note whether any edge occurred.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_fall) begin
            mod_cnt  <= '0;
            got_edge <= 1'b0;
        end else if (in_frame && sclk_fall) begin
            mod_cnt  <= (mod_cnt == LAST_POS) ? '0 : mod_cnt + 1'b1;
            got_edge <= 1'b1;
        end
    end

    // Count output positions on rising edges; saturate once forwarding starts.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_fall)
            out_pos <= '0;
        else if (in_frame && sclk_rise && got_edge && out_pos != FULL_POS)
            out_pos <= out_pos + 1'b1;
    end

    // Output bit: first bit at frame start, later bits after each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sdo_q <= 1'b0;
        else if (sync_fall)                          sdo_q <= preload[FRAME_W-1];
        else if (in_frame && sclk_rise && got_edge)  sdo_q <= sr[FRAME_W-1];
    end

    // At frame end, arm a read if the frame is valid and carries a read command; otherwise clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            arm_addr <= '0;
        end else if (sync_rise) begin
            armed <= frame_ok && is_rd;
            if (frame_ok && is_rd)
                arm_addr <= sr[FRAME_W-2 -: ADDR_W];
        end
    end

    // Write strobe and fields go to the register bank.
    assign wr_en   = sync_rise && frame_ok && !is_rd;
    assign wr_addr = sr[FRAME_W-2 -: ADDR_W];
    assign wr_data = sr[DATA_W-1:0];
    assign rd_addr = arm_addr;

    // Drive in the data field of an armed read, and in every forwarding position.
    assign sdo    = sdo_q;
    assign sdo_oe = in_frame && ((out_pos == FULL_POS) || (armed && out_pos >= HDR_POS));

    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_cnt <= LAST_POS);                                               // R3
    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_s) |=> !sdo_oe);                                       // R6
    AST_ARM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(sync_rise && got_edge && mod_cnt == '0));    // R4
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !sync_fall) |=> $stable(sr));                         // R9
endmodule

// File: rtl/spi_dc_regbank.sv
// Bank of 16-bit registers with one write port and one combinational read port.
// Assumes a write strobe that lasts one cycle; addresses past the bank return zero.
module spi_dc_regbank #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Load this register when the strobe carries its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs[i] <= wr_data;
        end

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(regs[i]));    // R8
    end

    // Return the selected register, or zero when the address has no register.
    always_comb begin
        rd_data = '0;
        if (rd_addr < TOP_ADDR)
            rd_data = regs[rd_addr[IDX_W-1:0]];
    end
endmodule

// File: rtl/spi_dc_slave.sv
// Top of the chainable serial register port: synchronizer, frame engine, register bank.
// Assumes clk is several times faster than the serial clock, and that a pull-up sits on the sdo pad.
module spi_dc_slave #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = spi_dc_pkg::CMD_W - 1,
    parameter int NUM_REGS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    import spi_dc_pkg::*;

    spi_pins_t         pins_raw, pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    assign pins_raw = '{sdi: sdi, sclk: sclk, sync_n: sync_n};

    spi_dc_sync #(
        .WIDTH   (PINS_W),
        .RST_VAL (PINS_W'(3'b001))
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    spi_dc_frame #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n_s (pins_s.sync_n),
        .sclk_s   (pins_s.sclk),
        .sdi_s    (pins_s.sdi),
        .rd_data  (rd_data),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr)
    );

    spi_dc_regbank #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/spi_dc_slave_bench.sv
// Three-device chain driven by one host; the host sees only the last device's output.
module spi_dc_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1, sclk = 1'b0, host_sdi = 1'b0;
    logic a_sdo, a_oe, b_sdo, b_oe, c_sdo, c_oe;
    logic b_in, c_in, host_miso;
    int   n_chk = 0, n_bad = 0, cycles = 0;
    bit   done = 1'b0;
    logic [15:0] model [3][8];

    localparam logic [23:0] NOP = 24'h7F_0000;
    localparam int NV = 14;
    // Vector: {device[1:0], read, address[6:0], data[15:0]}; device 0 = A, the first in the chain.
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 1'b0, 7'd1,  16'h1234}, {2'd1, 1'b0, 7'd1,  16'h5678},
        {2'd2, 1'b0, 7'd1,  16'h9ABC}, {2'd0, 1'b1, 7'd1,  16'h0000},
        {2'd1, 1'b1, 7'd1,  16'h0000}, {2'd2, 1'b1, 7'd1,  16'h0000},
        {2'd0, 1'b0, 7'd7,  16'hFEDC}, {2'd0, 1'b1, 7'd7,  16'h0000},
        {2'd1, 1'b0, 7'd0,  16'h0F0F}, {2'd2, 1'b1, 7'd0,  16'h0000},
        {2'd1, 1'b1, 7'd0,  16'h0000}, {2'd2, 1'b0, 7'd8,  16'hBEEF},
        {2'd2, 1'b1, 7'd8,  16'h0000}, {2'd2, 1'b1, 7'd1,  16'h0000}
    };

    always #2 clk = ~clk;

    // Released outputs are pulled up.
    assign b_in      = a_oe ? a_sdo : 1'b1;
    assign c_in      = b_oe ? b_sdo : 1'b1;
    assign host_miso = c_oe ? c_sdo : 1'b1;

    spi_dc_slave u_spi_dc_slave_a (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
                                   .sdi(host_sdi), .sdo(a_sdo), .sdo_oe(a_oe));
    spi_dc_slave u_spi_dc_slave_b (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
                                   .sdi(b_in), .sdo(b_sdo), .sdo_oe(b_oe));
    spi_dc_slave u_spi_dc_slave_c (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
                                   .sdi(c_in), .sdo(c_sdo), .sdo_oe(c_oe));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] cmd(input logic rd, input logic [6:0] a, input logic [15:0] d);
        return {rd, a, d};
    endfunction

    // One frame of n bits; tx[n-1] goes first, rx[n-1] is the first bit seen by the host.
    task automatic xfer(input int n, input logic [95:0] tx,
                        output logic [95:0] rx, output logic [95:0] rxoe);
        rx = '1; rxoe = '0;
        sync_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            host_sdi = tx[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            rx[i]   = host_miso;
            rxoe[i] = c_oe;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        sync_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic frame72(input int dev, input logic [23:0] word,
                           output logic [95:0] rx, output logic [95:0] rxoe);
        logic [95:0] tx;
        tx = {24'h0, NOP, NOP, NOP};
        tx[24*dev +: 24] = word;
        xfer(72, tx, rx, rxoe);
    endtask

    // Two-frame read: arm it, then collect the data from the next frame.
    task automatic do_read(input int dev, input logic [6:0] a, input logic [15:0] exp, input string tag);
        logic [95:0] rx, rxoe;
        frame72(dev, cmd(1'b1, a, 16'h0), rx, rxoe);
        xfer(72, {24'h0, NOP, NOP, NOP}, rx, rxoe);
        chk({tag, " R5 read data"}, 32'(rx[24*dev +: 16]), 32'(exp));
        chk("R5 R7 data/forward enable", 32'(rxoe[24*dev +: 16]), 32'hFFFF);
        chk("R5 R6 header released", 32'(rxoe[71:64]), 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 180000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 180000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [95:0] rx, rxoe, tx;
        logic [1:0]  dev;
        logic [6:0]  a;
        logic [15:0] d, exp;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 8; j++) model[i][j] = 16'h0;
        repeat (10) @(negedge clk);
        chk("R1 R6 enables in reset", 32'({a_oe, b_oe, c_oe}), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 idle enables", 32'({a_oe, b_oe, c_oe}), 32'h0);
        do_read(0, 7'd0, 16'h0000, "R1");
        do_read(2, 7'd5, 16'h0000, "R1");

        // Table walk: writes update the model, reads compare against it.
        for (int i = 0; i < NV; i++) begin
            dev = VEC[i][25:24];
            a   = VEC[i][22:16];
            d   = VEC[i][15:0];
            if (VEC[i][23]) begin
                exp = (a < 7'd8) ? model[dev][a[2:0]] : 16'h0;
                do_read(int'(dev), a, exp, (a < 7'd8) ? "R2" : "R8");
            end else begin
                frame72(int'(dev), cmd(1'b0, a, d), rx, rxoe);
                if (a < 7'd8) model[dev][a[2:0]] = d;
            end
        end

        // R9: serial clock toggling with select high changes nothing.
        for (int k = 0; k < 5; k++) begin
            host_sdi = k[0];
            sclk = 1'b1; repeat (8) @(negedge clk);
            sclk = 1'b0; repeat (8) @(negedge clk);
        end
        chk("R9 R6 enables while select high", 32'({a_oe, b_oe, c_oe}), 32'h0);
        do_read(1, 7'd1, 16'h5678, "R9");

        // R4: 23- and 25-edge write attempts to A register 1 are dropped.
        xfer(23, {73'h0, 23'(cmd(1'b0, 7'd1, 16'hDEAD))}, rx, rxoe);
        xfer(25, {71'h0, 1'b0, cmd(1'b0, 7'd1, 16'hDEAD)}, rx, rxoe);
        do_read(0, 7'd1, 16'h1234, "R4");

        // R4: a pending read is cancelled by a frame of invalid length.
        frame72(0, cmd(1'b1, 7'd7, 16'h0), rx, rxoe);
        xfer(25, {71'h0, 1'b0, NOP}, rx, rxoe);
        xfer(72, {24'h0, NOP, NOP, NOP}, rx, rxoe);
        chk("R4 no read after bad frame", 32'(rx[15:0]), 32'hFFFF);

        // R3 and R7: 96-edge frame; the first word is forwarded but never decoded.
        tx = {cmd(1'b0, 7'd2, 16'hBAD0), cmd(1'b0, 7'd2, 16'h1111),
              cmd(1'b0, 7'd2, 16'h2222), cmd(1'b0, 7'd2, 16'h3333)};
        xfer(96, tx, rx, rxoe);
        chk("R7 forwarded word", 32'(rx[23:0]), 32'(tx[95:72]));
        chk("R7 forward enable", 32'(rxoe[23:0]), 32'hFFFFFF);
        do_read(2, 7'd2, 16'h1111, "R3");
        do_read(1, 7'd2, 16'h2222, "R3");
        do_read(0, 7'd2, 16'h3333, "R3");
        chk("R6 enables after frames", 32'({a_oe, b_oe, c_oe}), 32'h0);

        // R1: reset clears registers written earlier.
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(0, 7'd7, 16'h0000, "R1");

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule